// File: doc/BRIEF.md
# Video RAM Host Port with Read-Ahead Buffer

This block is the host-facing path into the video memory of a tile or bitmap display controller. The host sees two byte-wide ports. Two successive writes to the control port set a 14-bit video RAM pointer and choose the transfer direction. The data port then moves bytes through one shared byte buffer. The buffer is exchanged with the 16K x 8 video RAM only when the display timing grants an access slot. A write is posted: the byte lands in the buffer at once and is committed at the next slot. A read setup, and every host read, schedules a prefetch into the same buffer. Host reads always return whatever the buffer holds, so a read issued before the prefetch has landed returns a stale byte.

The block has no wait or ready output. The host must space its accesses using the known slot rate. An internal slot generator produces 3 slots per 8 clocks in text mode and 4 slots per 11 clocks (2 per 5.5) otherwise, using a fractional accumulator. The pointer advances after every completed memory transfer and wraps at the end of memory. A sticky flag reports a posted byte that was overwritten before it could be committed.

The control FSM has five states. IDLE: buffer empty, nothing owed. WR_PEND: posted byte awaiting a slot. RD_PEND: prefetch awaiting a slot. RD_FILL: memory read in flight. RD_FULL: prefetched byte held. Its transitions are:
- setup-write: any state to IDLE.
- setup-read: any state to RD_PEND.
- host-write: any state to WR_PEND.
- host-read: any state to RD_PEND.
- commit: WR_PEND to IDLE at a slot.
- fetch: RD_PEND to RD_FILL at a slot.
- land: RD_FILL to RD_FULL on the next clock.

Top module: `vram_host_port`

## Requirements
- R1: After reset `dat_rdata` is 0x00 and `overrun` is 0, and the control port expects a low address byte.
- R2: The first control write supplies pointer bits 7:0. The second supplies pointer bits 13:8 in its bits 5:0 and the direction in bit 6 (1 = write, 0 = read). When bit 7 of the second byte is 1, the pair is not an address setup: pointer, buffer and state are left unchanged. A completed setup abandons any transfer still owed.
- R3: Any data-port access (read or write) returns the control port to expecting a low byte.
- R4: A data-port write is taken into the buffer on the same clock in every state, including right after a write setup. The buffered byte is written to RAM at the pointer on the first access slot after it was posted, and the pointer then increments.
- R5: A data-port write while a posted byte is still uncommitted, on a clock that is not an access slot, discards the old byte and sets `overrun`, which stays 1 until reset. If that clock is a slot, the old byte is committed first and `overrun` is not set.
- R6: After a read setup, the first access slot with no host data access reads RAM at the pointer. The byte appears in the buffer one clock later and the pointer increments.
- R7: `dat_rdata` always shows the buffer. A host read schedules a prefetch from the current pointer. A read issued while the prefetch has not yet happened returns the old buffer byte and leaves the pointer unchanged.
- R8: An accumulator starts at 0. Each clock it adds 3 (text_mode = 1) or 4 (text_mode = 0). When the sum reaches 8 (text) or 11 (other), that clock is an access slot and 8 or 11 is subtracted. Any 8 (text) or 11 (other) consecutive clocks in one mode therefore hold exactly 3 or 4 slots.
- R9: The pointer wraps from 0x3FFF to 0x0000.
- R10: When ports collide on one clock, the completing control write wins over a data write, which wins over a data read. A data write dropped this way leaves the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| text_mode | input | 1 | 1 selects the text-mode slot rate |
| ctl_we | input | 1 | Control port write strobe |
| ctl_wdata | input | 8 | Control port write byte |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Data port write byte |
| dat_re | input | 1 | Data port read strobe |
| dat_rdata | output | 8 | Buffer contents returned to the host |
| overrun | output | 1 | Sticky lost-posted-byte flag |

## Verification
The hardest states to reach from the ports are the ones that depend on where the hidden slot falls. These are two back-to-back data writes, either with no slot between them (overrun) or with a slot on the second clock (clean commit). The bench runs its own copy of the slot arithmetic and waits for the right accumulator phase before it issues the pair. The stale read needs no such alignment. A data read on the clock straight after a read setup always finds the prefetch still owed, so the bench preloads the buffer with a known byte through a write and then checks that this byte comes back instead of memory.

// File: rtl/vhp_pkg.sv
package vhp_pkg;
    localparam int VHP_ADDR_W = 14;
    localparam int VHP_DATA_W = 8;
    localparam int TXT_NUM    = 3;
    localparam int TXT_DEN    = 8;
    localparam int GFX_NUM    = 4;
    localparam int GFX_DEN    = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PEND,
        ST_RD_PEND,
        ST_RD_FILL,
        ST_RD_FULL
    } port_state_e;
endpackage

// File: rtl/vhp_slot_gen.sv
module vhp_slot_gen #(
    parameter int TXT_N = 3,
    parameter int TXT_D = 8,
    parameter int GFX_N = 4,
    parameter int GFX_D = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic text_mode,
    output logic slot
);
    localparam int MAX_D = (TXT_D > GFX_D) ? TXT_D : GFX_D;
    localparam int ACC_W = $clog2(2 * MAX_D);

    logic [ACC_W-1:0] acc_q, sum, num, den;

    always_comb begin
        num  = text_mode ? ACC_W'(TXT_N) : ACC_W'(GFX_N);
        den  = text_mode ? ACC_W'(TXT_D) : ACC_W'(GFX_D);
        sum  = acc_q + num;
        slot = (sum >= den);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (slot) acc_q <= sum - den;
        else           acc_q <= sum;
    end
endmodule

// File: rtl/vhp_ctl_decode.sv
module vhp_ctl_decode #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              dat_access,
    output logic              setup_go,
    output logic              setup_wr,
    output logic [ADDR_W-1:0] setup_addr
);
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int WR_BIT = HI_W;
    localparam int RG_BIT = DATA_W - 1;

    logic              second_q;
    logic [DATA_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q <= 1'b0;
            low_q    <= '0;
        end else if (ctl_we) begin
            second_q <= ~second_q;
            if (!second_q) low_q <= ctl_wdata;
        end else if (dat_access) begin
            second_q <= 1'b0;
        end
    end

    assign setup_go   = ctl_we && second_q && !ctl_wdata[RG_BIT];
    assign setup_wr   = ctl_wdata[WR_BIT];
    assign setup_addr = {ctl_wdata[HI_W-1:0], low_q};
endmodule

// File: rtl/vhp_vram.sv
module vhp_vram #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) q <= mem[addr];
    end
endmodule

// File: rtl/vram_host_port.sv
module vram_host_port
    import vhp_pkg::*;
#(
    parameter int ADDR_W = VHP_ADDR_W,
    parameter int DATA_W = VHP_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              text_mode,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              dat_re,
    output logic [DATA_W-1:0] dat_rdata,
    output logic              overrun
);
    port_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q, setup_addr;
    logic [DATA_W-1:0] buf_q, ram_q;
    logic              ovr_q, slot, setup_go, setup_wr;
    logic              host_wr, host_rd, ram_we, ram_re, fill_en;

    vhp_slot_gen #(
        .TXT_N(TXT_NUM), .TXT_D(TXT_DEN), .GFX_N(GFX_NUM), .GFX_D(GFX_DEN)
    ) slot_i (
        .clk(clk), .rst_n(rst_n), .text_mode(text_mode), .slot(slot)
    );

    vhp_ctl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctl_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_access(dat_we || dat_re), .setup_go(setup_go),
        .setup_wr(setup_wr), .setup_addr(setup_addr)
    );

    vhp_vram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
        .clk(clk), .we(ram_we), .re(ram_re), .addr(addr_q),
        .wdata(buf_q), .q(ram_q)
    );

    // Output decode: memory strobes and buffer fill
    always_comb begin
        host_wr = dat_we && !setup_go;
        host_rd = dat_re && !setup_go && !dat_we;
        ram_we  = (state_q == ST_WR_PEND) && slot && !setup_go;
        ram_re  = (state_q == ST_RD_PEND) && slot && !setup_go && !host_wr && !host_rd;
        fill_en = (state_q == ST_RD_FILL) && !setup_go && !host_wr && !host_rd;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (setup_go)     state_d = setup_wr ? ST_IDLE : ST_RD_PEND;
        else if (host_wr) state_d = ST_WR_PEND;
        else if (host_rd) state_d = ST_RD_PEND;
        else begin
            unique case (state_q)
                ST_WR_PEND: if (slot) state_d = ST_IDLE;
                ST_RD_PEND: if (slot) state_d = ST_RD_FILL;
                ST_RD_FILL: state_d = ST_RD_FULL;
                ST_IDLE, ST_RD_FULL: state_d = state_q;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pointer, buffer and overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            buf_q  <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (setup_go)              addr_q <= setup_addr;
            else if (ram_we || ram_re) addr_q <= addr_q + 1'b1;
            if (host_wr)               buf_q  <= dat_wdata;
            else if (fill_en)          buf_q  <= ram_q;
            if (host_wr && (state_q == ST_WR_PEND) && !slot) ovr_q <= 1'b1;
        end
    end

    assign dat_rdata = buf_q;
    assign overrun   = ovr_q;
endmodule

// File: rtl/vhp_port_chk.sv
module vhp_port_chk
    import vhp_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              text_mode,
    input logic              slot,
    input port_state_e       state,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] buf_q,
    input logic [DATA_W-1:0] ram_q,
    input logic              ram_we,
    input logic              setup_go,
    input logic              dat_we,
    input logic              dat_re,
    input logic              overrun
);
    logic       mode_q;
    logic [4:0] win_cnt, win_slots, num_now, den_now;
    logic       chg, win_end;

    always_comb begin
        num_now = text_mode ? 5'(TXT_NUM) : 5'(GFX_NUM);
        den_now = text_mode ? 5'(TXT_DEN) : 5'(GFX_DEN);
        chg     = (text_mode != mode_q);
        win_end = !chg && (win_cnt == den_now - 5'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= text_mode;
            win_cnt   <= '0;
            win_slots <= '0;
        end else begin
            mode_q <= text_mode;
            if (chg || win_end) begin
                win_cnt   <= '0;
                win_slots <= '0;
            end else begin
                win_cnt   <= win_cnt + 5'd1;
                win_slots <= win_slots + 5'(slot);
            end
        end
    end

    // R8
    slot_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> (win_slots + 5'(slot) == num_now));

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R5
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(state) == ST_WR_PEND) && !$past(slot));

    // R4
    commit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> slot);

    // R9
    commit_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> addr == ADDR_W'($past(addr) + 1'b1));

    // R6
    fill_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_FILL && !setup_go && !dat_we && !dat_re) |=> buf_q == $past(ram_q));

    // R7
    stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_PEND && dat_re && !dat_we && !setup_go)
        |=> (addr == $past(addr)) && (state == ST_RD_PEND));
endmodule

bind vram_host_port vhp_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .text_mode(text_mode), .slot(slot),
    .state(state_q), .addr(addr_q), .buf_q(buf_q), .ram_q(ram_q),
    .ram_we(ram_we), .setup_go(setup_go), .dat_we(dat_we), .dat_re(dat_re),
    .overrun(overrun)
);

// File: tb/vram_host_port_tb.sv
module vram_host_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       text_mode = 1'b0;
    logic       ctl_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
    logic [7:0] ctl_wdata = '0, dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       overrun;
    int         n_run = 0, n_fail = 0;
    int         m_acc = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    vram_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .text_mode(text_mode),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re),
        .dat_rdata(dat_rdata), .overrun(overrun)
    );

    // Slot arithmetic from R8
    function automatic bit slot_of(input int acc, input bit tm);
        return (acc + (tm ? 3 : 4)) >= (tm ? 8 : 11);
    endfunction
    function automatic int step(input int acc, input bit tm);
        int s = acc + (tm ? 3 : 4);
        return (s >= (tm ? 8 : 11)) ? s - (tm ? 8 : 11) : s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_acc <= 0;
        else        m_acc <= step(m_acc, text_mode);
    end

    function automatic logic [7:0] pat(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], a[13:12]} ^ 8'h5A;
    endfunction

    task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic check1(input string req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    // All operations start at a falling edge and occupy one rising edge
    task automatic op_ctl(input logic [7:0] b);
        ctl_we = 1'b1; ctl_wdata = b;
        @(negedge clk); ctl_we = 1'b0;
    endtask
    task automatic op_wr(input logic [7:0] b);
        dat_we = 1'b1; dat_wdata = b;
        @(negedge clk); dat_we = 1'b0;
    endtask
    task automatic op_rd(output logic [7:0] b);
        dat_re = 1'b1; b = dat_rdata;
        @(negedge clk); dat_re = 1'b0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic setup(input logic [13:0] a, input bit wr);
        op_ctl(a[7:0]);
        op_ctl({1'b0, wr, a[13:8]});
    endtask
    task automatic read_seq(input logic [13:0] a, input int n, input string req);
        logic [7:0] v;
        setup(a, 1'b0); idle(12);
        for (int i = 0; i < n; i++) begin
            op_rd(v); check8(req, v, pat(a + 14'(i))); idle(12);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        check8("R1 rdata", dat_rdata, 8'h00);
        check1("R1 overrun", overrun, 1'b0);

        // R4 R6 sweeps in both slot modes
        for (int m = 0; m < 2; m++) begin
            logic [13:0] base = (m == 0) ? 14'h0100 : 14'h2A00;
            text_mode = m[0];
            setup(base, 1'b1);
            for (int i = 0; i < 64; i++) begin
                op_wr(pat(base + 14'(i))); idle(12);
            end
            read_seq(base, 64, m == 0 ? "R4 R6 gfx sweep" : "R4 R6 R8 text sweep");
        end
        text_mode = 1'b0;

        // R2 every high-byte value
        for (int h = 0; h < 64; h++) begin
            logic [13:0] a = {6'(h), 8'(h * 37 + 11)};
            setup(a, 1'b1); op_wr(pat(a)); idle(12);
        end
        for (int h = 0; h < 64; h++) begin
            logic [13:0] a = {6'(h), 8'(h * 37 + 11)};
            setup(a, 1'b0); idle(12); op_rd(v);
            check8("R2 high byte sweep", v, pat(a)); idle(4);
        end

        // R9 wrap
        setup(14'h3FFF, 1'b1); op_wr(8'hAA); idle(12); op_wr(8'h55); idle(12);
        setup(14'h3FFF, 1'b0); idle(12);
        op_rd(v); check8("R9 last", v, 8'hAA); idle(12);
        op_rd(v); check8("R9 wrapped", v, 8'h55); idle(12);

        // R7 stale read straight after read setup
        setup(14'h0200, 1'b1); op_wr(8'hC3); idle(12);
        setup(14'h0100, 1'b0);
        op_rd(v); check8("R7 stale", v, 8'hC3); idle(12);
        op_rd(v); check8("R7 same pointer", v, pat(14'h0100)); idle(12);
        op_rd(v); check8("R7 next", v, pat(14'h0101)); idle(12);

        // R2 bit 7 set: no setup, buffer keeps prefetched 0x0102
        op_ctl(8'h00); op_ctl(8'hAA); idle(12);
        check8("R2 bit7 ignored", dat_rdata, pat(14'h0102));
        op_rd(v); check8("R2 bit7 pointer kept", v, pat(14'h0102)); idle(12);

        // R4 write right after setup
        setup(14'h0300, 1'b1); op_wr(8'h11); idle(12);
        check1("R4 no overrun", overrun, 1'b0);
        op_wr(8'h22); idle(12);

        // R3 data access resets the control phase
        op_ctl(8'h40); op_rd(v); op_ctl(8'h00); op_ctl(8'h03); idle(12);
        op_rd(v); check8("R3 phase reset", v, 8'h11); idle(12);
        check8("R3 prefetch next", dat_rdata, 8'h22);

        // R10 control write beats data write
        op_ctl(8'h00);
        ctl_we = 1'b1; ctl_wdata = 8'h43; dat_we = 1'b1; dat_wdata = 8'h99;
        @(negedge clk); ctl_we = 1'b0; dat_we = 1'b0; idle(12);
        check8("R10 data dropped", dat_rdata, 8'h22);
        op_wr(8'h77); idle(12);
        setup(14'h0300, 1'b0); idle(12);
        op_rd(v); check8("R10 setup took effect", v, 8'h77); idle(4);

        // R5 second write lands on a slot: no overrun
        setup(14'h0400, 1'b1);
        while (slot_of(m_acc, 1'b0) || !slot_of(step(m_acc, 1'b0), 1'b0)) @(negedge clk);
        op_wr(8'h31); op_wr(8'h32); idle(12);
        check1("R5 slot coincident", overrun, 1'b0);

        // R5 second write with no slot: overrun
        setup(14'h0500, 1'b1);
        while (slot_of(m_acc, 1'b0) || slot_of(step(m_acc, 1'b0), 1'b0)) @(negedge clk);
        op_wr(8'h41); op_wr(8'h42);
        check1("R5 overrun set", overrun, 1'b1); idle(12);
        setup(14'h0500, 1'b0); idle(12);
        op_rd(v); check8("R5 newer byte kept", v, 8'h42); idle(12);
        setup(14'h0400, 1'b0); idle(12);
        op_rd(v); check8("R5 first committed", v, 8'h31); idle(12);
        op_rd(v); check8("R5 second committed", v, 8'h32); idle(12);
        check1("R5 sticky", overrun, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule